// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is a self-running two-wire bus master for a small serial configuration memory. Software writes one 32-bit command word, and the engine then performs a whole addressed transaction on the bus without further help. A write stores one byte at an 8-bit location. A read sends the location, turns the bus round with a repeated START, and fetches one byte or four consecutive bytes. Both bus lines are open-drain: the block only pulls a line low or releases it, and it reads the data line back through `sdaIn`.

When the transaction ends, a status byte reports completion and the acknowledge outcome of each addressing phase. For reads, a 32-bit result word holds the fetched data. The bus clock runs at a fixed fraction of the system clock, set by a parameter that gives the number of system clocks in each quarter of an SCL period.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: After reset, `status` is 8'h01 (bit 0 = done), `readData` is 0, and both `sclDrvLow` and `sdaDrvLow` are 0. Whenever done is 1, both lines are released.
- R2: Command word fields are as follows. Bit 0 selects the direction (1 = read, 0 = write). Bit 1 selects the read size (1 = four bytes, 0 = one byte). Bits 15:8 hold the byte to write, bits 23:16 the memory location, and bits 31:25 the 7-bit device address. A `cmdWe` pulse while done is 1 starts a transaction and, on the next clock, clears done, `status[7:5]` and `readData`.
- R3: A write sends START, the device address with R/W=0, the location, the data byte, then STOP. The memory ends up holding the byte, and the acknowledge of the data byte is not reported in `status`.
- R4: A single-byte read sends START, device address with R/W=0, location, repeated START, device address with R/W=1. It then reads one byte into `readData[7:0]`, answers it with no-acknowledge, and sends STOP. Bits 31:8 stay 0.
- R5: A four-byte read places the first byte received in `readData[7:0]` and each later byte in the next higher byte lane. The master acknowledges the first three bytes and not the fourth.
- R6: If the first device-address byte is not acknowledged, `status[7]` is set, the engine sends STOP at once, and done is set. No memory location is changed.
- R7: If the location byte is not acknowledged, `status[6]` is set and the transaction is aborted with STOP. On a read, no data is fetched and `readData` stays 0.
- R8: If the device-address byte sent with R/W=1 is not acknowledged, `status[5]` is set, the engine sends STOP, and `readData` stays 0.
- R9: A `cmdWe` pulse while a transaction is running (done = 0) is ignored. The running transaction completes unchanged, and no second transaction follows it.
- R10: The SCL period within a byte is exactly 4 × `QUARTER_CLKS` system clocks.
- R11: Done stays 0 from START to STOP on the bus. Once set, done, `status` and `readData` hold until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWe | input | 1 | One-cycle strobe that writes the command word |
| cmdData | input | 32 | Command word |
| sdaIn | input | 1 | Level sensed on the bus data line |
| sclDrvLow | output | 1 | 1 pulls the clock line low, 0 releases it |
| sdaDrvLow | output | 1 | 1 pulls the data line low, 0 releases it |
| status | output | 8 | Bit 0 = done; bits 7/6/5 = no-ack on device address, location, second device address |
| readData | output | 32 | Bytes fetched by the last read, lowest lane first |

## Verification
The hardest conditions to reach from the ports are the abort paths, above all a refusal of the second device-address byte. That byte comes only after a repeated START and a location that was already acknowledged. The bench reaches these paths with a behavioural memory model on the open-drain lines. The model can be told to refuse a foreign device address, the location byte, or the read-direction address. Commands written during a running transaction are aimed at a second location, so the bench can see afterwards from memory contents alone whether they were obeyed.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  localparam int RD_BYTES  = 4;
  localparam int RD_DATA_W = 8 * RD_BYTES;
  localparam int LANE_W    = $clog2(RD_BYTES);

  typedef enum logic [1:0] {
    SYM_START = 2'd0,
    SYM_STOP  = 2'd1,
    SYM_TX    = 2'd2,
    SYM_RX    = 2'd3
  } symKind_t;

  // control -> datapath
  typedef struct packed {
    logic       go;
    symKind_t   kind;
    logic [7:0] txByte;
    logic       nackOut;
  } bitCmd_t;

  // datapath -> control
  typedef struct packed {
    logic       symDone;
    logic [7:0] rxByte;
    logic       ackMissing;
  } bitRsp_t;

endpackage

// File: rtl/eeprom_bitdp.sv
module eeprom_bitdp
  import eeprom_pkg::*;
#(
  parameter int QUARTER_CLKS = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  bitCmd_t cmd,
  input  logic    sdaIn,
  output bitRsp_t rsp,
  output logic    sclDrvLow,
  output logic    sdaDrvLow
);

  localparam int CW = $clog2(QUARTER_CLKS);
  localparam logic [CW-1:0] DIV_LAST = CW'(QUARTER_CLKS - 1);

  logic          busy;
  symKind_t      kind;
  logic [1:0]    quarter;
  logic [3:0]    slot;
  logic [CW-1:0] divCnt;
  logic [8:0]    shiftOut;
  logic [7:0]    shiftIn;
  logic          ackMissing;
  logic          symDone;
  logic          sclLvl, sdaLvl;
  logic          nextScl, nextSda;
  logic          tick;
  logic [3:0]    lastSlot;

  assign tick     = busy && (divCnt == DIV_LAST);
  assign lastSlot = (kind == SYM_TX || kind == SYM_RX) ? 4'd8 : 4'd0;

  // Line levels for the current quarter of the current symbol
  always_comb begin
    unique case (kind)
      SYM_START: begin
        nextScl = (quarter == 2'd1) || (quarter == 2'd2);
        nextSda = (quarter == 2'd0) || (quarter == 2'd1);
      end
      SYM_STOP: begin
        nextScl = (quarter != 2'd0);
        nextSda = (quarter == 2'd2) || (quarter == 2'd3);
      end
      default: begin
        nextScl = (quarter == 2'd1) || (quarter == 2'd2);
        nextSda = shiftOut[8];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      kind       <= SYM_STOP;
      quarter    <= 2'd0;
      slot       <= 4'd0;
      divCnt     <= '0;
      shiftOut   <= '1;
      shiftIn    <= '0;
      ackMissing <= 1'b0;
      symDone    <= 1'b0;
      sclLvl     <= 1'b1;
      sdaLvl     <= 1'b1;
    end else begin
      symDone <= 1'b0;
      if (!busy) begin
        if (cmd.go) begin
          busy     <= 1'b1;
          kind     <= cmd.kind;
          quarter  <= 2'd0;
          slot     <= 4'd0;
          divCnt   <= '0;
          shiftOut <= (cmd.kind == SYM_TX) ? {cmd.txByte, 1'b1} : {8'hFF, cmd.nackOut};
        end
      end else begin
        sclLvl <= nextScl;
        sdaLvl <= nextSda;
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) begin
          if (quarter == 2'd2) begin
            if (slot == 4'd8) ackMissing <= sdaIn;
            else              shiftIn    <= {shiftIn[6:0], sdaIn};
          end
          quarter <= quarter + 2'd1;
          if (quarter == 2'd3) begin
            shiftOut <= {shiftOut[7:0], 1'b1};
            if (slot == lastSlot) begin
              busy    <= 1'b0;
              symDone <= 1'b1;
            end else begin
              slot <= slot + 4'd1;
            end
          end
        end
      end
    end
  end

  assign rsp.symDone    = symDone;
  assign rsp.rxByte     = shiftIn;
  assign rsp.ackMissing = ackMissing;
  assign sclDrvLow      = ~sclLvl;
  assign sdaDrvLow      = ~sdaLvl;

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdWe,
  input  logic [31:0]          cmdData,
  input  bitRsp_t              rsp,
  output bitCmd_t              cmd,
  output logic [7:0]           status,
  output logic [RD_DATA_W-1:0] readData
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_DEVW, ST_MADDR, ST_WDATA,
    ST_RSTART, ST_DEVR, ST_RXB, ST_STOP
  } phase_t;

  phase_t            state;
  logic [31:0]       cmdReg;
  logic              pending;
  logic [LANE_W-1:0] byteCnt;
  logic [2:0]        ackBits;
  logic              done;

  logic              isRead, isQuad;
  logic [7:0]        wByte, mAddr;
  logic [6:0]        devAddr;
  logic [LANE_W-1:0] lastIdx;
  logic              unusedCmdBits;

  assign isRead        = cmdReg[0];
  assign isQuad        = cmdReg[1];
  assign wByte         = cmdReg[15:8];
  assign mAddr         = cmdReg[23:16];
  assign devAddr       = cmdReg[31:25];
  assign unusedCmdBits = ^{cmdReg[24], cmdReg[7:2]};
  assign lastIdx       = isQuad ? LANE_W'(RD_BYTES - 1) : '0;

  always_comb begin
    cmd.go      = (state != ST_IDLE) && !pending;
    cmd.kind    = SYM_TX;
    cmd.txByte  = 8'hFF;
    cmd.nackOut = 1'b1;
    unique case (state)
      ST_START, ST_RSTART: cmd.kind = SYM_START;
      ST_STOP:             cmd.kind = SYM_STOP;
      ST_DEVW:             cmd.txByte = {devAddr, 1'b0};
      ST_MADDR:            cmd.txByte = mAddr;
      ST_WDATA:            cmd.txByte = wByte;
      ST_DEVR:             cmd.txByte = {devAddr, 1'b1};
      ST_RXB: begin
        cmd.kind    = SYM_RX;
        cmd.nackOut = (byteCnt == lastIdx);
      end
      default: cmd.go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cmdReg   <= '0;
      pending  <= 1'b0;
      byteCnt  <= '0;
      ackBits  <= '0;
      done     <= 1'b1;
      readData <= '0;
    end else if (state == ST_IDLE) begin
      if (cmdWe) begin
        cmdReg   <= cmdData;
        state    <= ST_START;
        done     <= 1'b0;
        ackBits  <= '0;
        readData <= '0;
        byteCnt  <= '0;
        pending  <= 1'b0;
      end
    end else begin
      if (cmd.go) pending <= 1'b1;
      if (rsp.symDone) begin
        pending <= 1'b0;
        unique case (state)
          ST_START: state <= ST_DEVW;
          ST_DEVW: begin
            if (rsp.ackMissing) begin ackBits[2] <= 1'b1; state <= ST_STOP; end
            else                  state <= ST_MADDR;
          end
          ST_MADDR: begin
            if (rsp.ackMissing) begin ackBits[1] <= 1'b1; state <= ST_STOP; end
            else                  state <= isRead ? ST_RSTART : ST_WDATA;
          end
          ST_WDATA:  state <= ST_STOP;
          ST_RSTART: state <= ST_DEVR;
          ST_DEVR: begin
            if (rsp.ackMissing) begin ackBits[0] <= 1'b1; state <= ST_STOP; end
            else                  state <= ST_RXB;
          end
          ST_RXB: begin
            readData[{byteCnt, 3'b000} +: 8] <= rsp.rxByte;
            if (byteCnt == lastIdx) state <= ST_STOP;
            else                    byteCnt <= byteCnt + 1'b1;
          end
          ST_STOP: begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign status = {ackBits, 4'b0000, done};

endmodule

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine
  import eeprom_pkg::*;
#(
  parameter int QUARTER_CLKS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWe,
  input  logic [31:0] cmdData,
  input  logic        sdaIn,
  output logic        sclDrvLow,
  output logic        sdaDrvLow,
  output logic [7:0]  status,
  output logic [31:0] readData
);

  bitCmd_t bitCmd;
  bitRsp_t bitRsp;

  eeprom_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWe    (cmdWe),
    .cmdData  (cmdData),
    .rsp      (bitRsp),
    .cmd      (bitCmd),
    .status   (status),
    .readData (readData)
  );

  eeprom_bitdp #(.QUARTER_CLKS(QUARTER_CLKS)) uBits (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (bitCmd),
    .sdaIn     (sdaIn),
    .rsp       (bitRsp),
    .sclDrvLow (sclDrvLow),
    .sdaDrvLow (sdaDrvLow)
  );

endmodule

// File: rtl/eeprom_cmd_engine_checker.sv
module eeprom_cmd_engine_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cmdWe,
  input logic        sclDrvLow,
  input logic        sdaDrvLow,
  input logic [7:0]  status,
  input logic [31:0] readData
);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    status[0] |-> (!sclDrvLow && !sdaDrvLow));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWe && status[0]) |=> (!status[0] && status[7:5] == 3'b000 && readData == 32'h0));

  p_dev_nack_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[7]) |-> !status[0]);

  p_loc_nack_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[6]) |-> !status[0]);

  p_rdev_nack_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[5]) |-> !status[0]);

  p_done_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    (status[0] && !cmdWe) |=> (status[0] && $stable(status) && $stable(readData)));

endmodule

bind eeprom_cmd_engine eeprom_cmd_engine_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdWe     (cmdWe),
  .sclDrvLow (sclDrvLow),
  .sdaDrvLow (sdaDrvLow),
  .status    (status),
  .readData  (readData)
);

// File: tb/eeprom_cmd_engine_test.sv
module eeprom_cmd_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int QCLKS      = 4;
  localparam logic [6:0] MY_DEV = 7'h50;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWe = 1'b0;
  logic [31:0] cmdData = '0;
  logic        sclDrvLow, sdaDrvLow;
  logic [7:0]  status;
  logic [31:0] readData;
  logic        slvDrv = 1'b0;
  logic        sclLine, sdaLine;

  int compared = 0;
  int mismatched = 0;

  assign sclLine = !sclDrvLow;
  assign sdaLine = !(sdaDrvLow || slvDrv);

  always #(CLK_PERIOD/2) clk = !clk;

  eeprom_cmd_engine #(.QUARTER_CLKS(QCLKS)) uut (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdData(cmdData), .sdaIn(sdaLine),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .status(status), .readData(readData)
  );

  // ---------------- behavioural memory model on the bus ----------------
  logic [7:0] mem [256];
  logic [7:0] shIn, txB, ptr;
  int  phase = 0, nextPhase = 0, bitCnt = 0;
  bit  sawRise = 0, masterAck = 0, busFlag = 0;
  bit  prevScl = 1, prevSda = 1;
  bit  nackMem = 0, nackRead = 0;
  int  ackCnt = 0, nackCnt = 0;
  int  cyc = 0, lastRise = -1, minGap = 1000000;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      compared++;
      if (busFlag && status[0]) begin
        mismatched++;
        $display("FAIL R11 done=%0d while bus busy, expected 0", status[0]);
      end
    end
    if (sclLine && prevScl && prevSda && !sdaLine) begin
      busFlag = 1; phase = 1; bitCnt = 0; sawRise = 0; slvDrv = 0;
    end else if (sclLine && prevScl && !prevSda && sdaLine) begin
      busFlag = 0; phase = 0; slvDrv = 0;
    end else if (sclLine && !prevScl) begin
      sawRise = 1;
      if (lastRise >= 0 && (cyc - lastRise) < minGap) minGap = cyc - lastRise;
      lastRise = cyc;
      if (phase != 0) begin
        if (bitCnt < 8) shIn = {shIn[6:0], sdaLine};
        else if (phase == 4) begin
          masterAck = !sdaLine;
          if (sdaLine) nackCnt++; else ackCnt++;
        end
      end
    end else if (!sclLine && prevScl && sawRise) begin
      sawRise = 0;
      if (phase != 0) begin
        bitCnt++;
        if (bitCnt == 8) begin
          if (phase == 4) slvDrv = 0;
          else begin
            bit ok;
            ok = 0;
            if (phase == 1) begin
              if (shIn[7:1] == MY_DEV) begin
                if (shIn[0]) begin ok = !nackRead; nextPhase = 4; end
                else begin ok = 1; nextPhase = 2; end
              end
            end else if (phase == 2) begin
              ok = !nackMem; ptr = shIn; nextPhase = 3;
            end else begin
              ok = 1; mem[ptr] = shIn; ptr = ptr + 8'd1; nextPhase = 3;
            end
            if (!ok) nextPhase = 0;
            slvDrv = ok;
          end
        end else if (bitCnt == 9) begin
          bitCnt = 0; slvDrv = 0;
          if (phase != 4) begin
            phase = nextPhase;
            if (phase == 4) begin txB = mem[ptr]; slvDrv = !txB[7]; end
          end else if (masterAck) begin
            ptr = ptr + 8'd1; txB = mem[ptr]; slvDrv = !txB[7];
          end else phase = 0;
        end else if (phase == 4) begin
          slvDrv = !txB[7 - bitCnt];
        end
      end
    end
    prevScl = sclLine;
    prevSda = sdaLine;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input logic [6:0] dev, input logic [7:0] loc,
                                        input logic [7:0] wd, input bit rd, input bit quad);
    return {dev, 1'b0, loc, wd, 6'b0, quad, rd};
  endfunction

  task automatic sendCmd(input logic [31:0] c);
    @(negedge clk); cmdWe = 1'b1; cmdData = c;
    @(negedge clk); cmdWe = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20000; i++) begin
      if (status[0]) return;
      @(negedge clk);
    end
    mismatched++;
    $display("FAIL R11 done never set, expected 1");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h20] = 8'h11; mem[8'h21] = 8'h22; mem[8'h22] = 8'h33; mem[8'h23] = 8'h44;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 status", {24'h0, status}, 32'h01);
    check("R1 readData", readData, 32'h0);
    check("R1 lines", {30'h0, sclDrvLow, sdaDrvLow}, 32'h0);

    // R2/R3 write one byte
    sendCmd(mkCmd(MY_DEV, 8'h10, 8'hA5, 0, 0));
    check("R2 done cleared", {31'h0, status[0]}, 32'h0);
    waitDone();
    check("R3 memory written", {24'h0, mem[8'h10]}, 32'hA5);
    check("R3 status", {24'h0, status}, 32'h01);
    check("R10 SCL period", minGap, 4 * QCLKS);

    // R4 single read
    ackCnt = 0; nackCnt = 0;
    sendCmd(mkCmd(MY_DEV, 8'h10, 8'h00, 1, 0));
    waitDone();
    check("R4 readData", readData, 32'h0000_00A5);
    check("R4 status", {24'h0, status}, 32'h01);
    check("R4 master acks", ackCnt, 0);
    check("R4 master nacks", nackCnt, 1);

    // R5 four-byte read
    ackCnt = 0; nackCnt = 0;
    sendCmd(mkCmd(MY_DEV, 8'h20, 8'h00, 1, 1));
    waitDone();
    check("R5 readData lanes", readData, 32'h4433_2211);
    check("R5 master acks", ackCnt, 3);
    check("R5 master nacks", nackCnt, 1);
    repeat (10) @(negedge clk);
    check("R11 readData held", readData, 32'h4433_2211);

    // R6 foreign device address; R2 readData cleared by new command
    sendCmd(mkCmd(7'h51, 8'h40, 8'h3C, 0, 0));
    check("R2 readData cleared", readData, 32'h0);
    waitDone();
    check("R6 status", {24'h0, status}, 32'h81);
    check("R6 memory untouched", {24'h0, mem[8'h40]}, 32'h00);
    check("R6 stop seen", {31'h0, busFlag}, 32'h0);
    check("R6 lines released", {30'h0, sclDrvLow, sdaDrvLow}, 32'h0);

    // R7 location refused on a read
    nackMem = 1;
    sendCmd(mkCmd(MY_DEV, 8'h20, 8'h00, 1, 1));
    waitDone();
    nackMem = 0;
    check("R7 status", {24'h0, status}, 32'h41);
    check("R7 readData", readData, 32'h0);
    check("R7 stop seen", {31'h0, busFlag}, 32'h0);

    // R8 read-direction address refused
    nackRead = 1;
    sendCmd(mkCmd(MY_DEV, 8'h20, 8'h00, 1, 0));
    waitDone();
    nackRead = 0;
    check("R8 status", {24'h0, status}, 32'h21);
    check("R8 readData", readData, 32'h0);

    // R9 command while busy is ignored
    sendCmd(mkCmd(MY_DEV, 8'h30, 8'h5A, 0, 0));
    repeat (50) @(negedge clk);
    sendCmd(mkCmd(MY_DEV, 8'h31, 8'h77, 0, 0));
    waitDone();
    repeat (30) @(negedge clk);
    check("R9 first write done", {24'h0, mem[8'h30]}, 32'h5A);
    check("R9 second write ignored", {24'h0, mem[8'h31]}, 32'h00);
    check("R9 stays done", {24'h0, status}, 32'h01);

    summary();
  end

endmodule